// File: doc/BRIEF.md
# J1850 Link Error Classifier

This block sits beside a J1850 data-link controller and turns the symbol-level events reported by an upstream decoder into a small set of error vectors for the CPU. It runs an 8-bit CRC over every received byte of a frame, including the trailing check byte. At end of data it tests the register against the fixed good-frame residue 0xC4. It also watches for bad symbols, misplaced end symbols, collisions while this node sends its end-of-data symbol, BREAK, and a bus stuck high or stuck low.

Detected faults become codes in a two-entry pending queue that is ordered by priority. The interrupt stays raised while the queue holds anything. Each CPU read returns the head code and removes it. After a BREAK the block stops taking frame events. It waits for the bus to go passive, then for a start-of-frame symbol. It also drives a transmit inhibit while the bus is held active, and a sticky transmit abort when the node's own start-of-frame never shows on the bus.

Top module: `j1850_err_vector`

## Requirements
- R1: A CRC register preset to 0xFF on each SOF takes in every received byte MSB first, using polynomial x^8+x^4+x^3+x^2+1. On an on-boundary EOD, a final value other than 0xC4 queues code 0x18, and a value equal to 0xC4 queues nothing.
- R2: An invalid or out-of-range symbol while the node is not transmitting queues code 0x1C only.
- R3: An invalid or out-of-range symbol while transmitting queues 0x14 and 0x1C. The next read returns 0x14 and the one after returns 0x1C.
- R4: An EOD or EOF symbol when the byte-boundary input is low queues 0x1C.
- R5: An active symbol while this node is sending EOD queues 0x1C.
- R6: A BREAK queues 0x1C, raises irq_o and sets hunt_o. While hunting, all other symbol and data events are ignored. hunt_o stays high until the bus has been passive for a cycle and a later SOF has arrived.
- R7: After reset vec_o is 0x00 and irq_o is low. Each vec_rd_i pulse removes the head code. Reading an empty queue returns 0x00. irq_o is high exactly while the queue is non-empty.
- R8: The queue is ordered 0x14 ahead of 0x1C ahead of 0x18 and holds at most two distinct codes. When a third code is pending, the lowest-priority code is dropped.
- R9: tx_inhibit_o is high in every cycle in which bus_dom_i is high.
- R10: If tx_sof_i is high with bus_dom_i low for SOF_CHK_CYC consecutive cycles, 0x1C is queued and tx_abort_o rises. tx_abort_o then holds, together with tx_inhibit_o, until a tx_cmd_i pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sym_sof_i | input | 1 | Start-of-frame symbol strobe |
| sym_eod_i | input | 1 | End-of-data symbol strobe |
| sym_eof_i | input | 1 | End-of-frame symbol strobe |
| sym_brk_i | input | 1 | BREAK symbol strobe |
| sym_bad_i | input | 1 | Invalid or out-of-range symbol strobe |
| sym_act_i | input | 1 | Active symbol seen on the bus |
| byte_edge_i | input | 1 | Bit count is on a byte boundary |
| rx_data_i | input | 8 | Received byte |
| rx_valid_i | input | 1 | Received byte strobe |
| tx_active_i | input | 1 | Node is transmitting |
| tx_eod_i | input | 1 | Node is sending its EOD symbol |
| tx_sof_i | input | 1 | Node is driving its SOF symbol |
| tx_cmd_i | input | 1 | CPU transmit command pulse |
| bus_dom_i | input | 1 | Sampled bus level, 1 = active |
| vec_rd_i | input | 1 | CPU read strobe, pops the head code |
| vec_o | output | 8 | Head error code, 0x00 when empty |
| irq_o | output | 1 | Error pending |
| tx_abort_o | output | 1 | Transmission aborted, waiting for a new command |
| tx_inhibit_o | output | 1 | Transmission start not allowed |
| hunt_o | output | 1 | Waiting for passive bus, then SOF |

## Verification
The hardest case to reach is the queue holding three distinct codes, which is the only way to show the drop rule. The bench first ends a frame with a corrupted check byte, leaving 0x18 pending. Before any read, it injects a bad symbol while transmitting, which adds 0x14 and 0x1C in the same cycle. The reads that follow must return 0x14, then 0x1C, then 0x00. The BREAK recovery is also checked across both of its waiting phases. While still waiting for a passive bus, a bad symbol and an off-boundary EOD are injected, and neither may add a code.

// File: rtl/j1850_err_pkg.sv
package j1850_err_pkg;
  localparam logic [7:0] VEC_NONE = 8'h00;
  localparam logic [7:0] VEC_LOA  = 8'h14;
  localparam logic [7:0] VEC_CRC  = 8'h18;
  localparam logic [7:0] VEC_INV  = 8'h1C;
  localparam logic [7:0] CRC_POLY = 8'h1D;
  localparam logic [7:0] CRC_INIT = 8'hFF;
  localparam logic [7:0] CRC_GOOD = 8'hC4;

  // pending-bit index: higher index = higher priority
  localparam int unsigned NCODE = 3;
  localparam int unsigned IDX_CRC = 0;
  localparam int unsigned IDX_INV = 1;
  localparam int unsigned IDX_LOA = 2;

  typedef enum logic [1:0] {ST_RUN, ST_WAIT_IDLE, ST_WAIT_SOF} hunt_st_e;

  function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] d);
    logic [7:0] c;
    c = crc;
    for (int i = 7; i >= 0; i--) begin
      if (c[7] ^ d[i]) c = (c << 1) ^ CRC_POLY;
      else             c = c << 1;
    end
    return c;
  endfunction
endpackage

// File: rtl/j1850_crc8.sv
module j1850_crc8
  import j1850_err_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         init_i,
  input  logic         en_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] crc_o
);
  logic [W-1:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= CRC_INIT;
    else if (init_i) crc_q <= CRC_INIT;
    else if (en_i)   crc_q <= crc8_step(crc_q, data_i);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/j1850_vec_queue.sv
module j1850_vec_queue
  import j1850_err_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NCODE-1:0] push_i,
  input  logic             pop_i,
  output logic [7:0]       head_o,
  output logic             busy_o
);
  logic [NCODE-1:0] pend_q, pend_d, top_oh, merged;
  int unsigned cnt;

  always_comb begin
    top_oh = '0;
    head_o = VEC_NONE;
    if (pend_q[IDX_LOA]) begin
      top_oh[IDX_LOA] = 1'b1; head_o = VEC_LOA;
    end else if (pend_q[IDX_INV]) begin
      top_oh[IDX_INV] = 1'b1; head_o = VEC_INV;
    end else if (pend_q[IDX_CRC]) begin
      top_oh[IDX_CRC] = 1'b1; head_o = VEC_CRC;
    end
  end

  always_comb begin
    merged = (pend_q & ~(pop_i ? top_oh : '0)) | push_i;
    pend_d = merged;
    cnt    = $countones(merged);
    // overflow: drop lowest-priority entries
    for (int i = 0; i < NCODE; i++) begin
      if (cnt > DEPTH && pend_d[i]) begin
        pend_d[i] = 1'b0;
        cnt       = cnt - 1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign busy_o = |pend_q;
endmodule

// File: rtl/j1850_hunt_fsm.sv
module j1850_hunt_fsm
  import j1850_err_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic brk_i,
  input  logic bus_dom_i,
  input  logic sof_i,
  output logic hunt_o
);
  hunt_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN:       if (brk_i) st_d = ST_WAIT_IDLE;
      ST_WAIT_IDLE: if (!brk_i && !bus_dom_i) st_d = ST_WAIT_SOF;
      ST_WAIT_SOF:  if (brk_i) st_d = ST_WAIT_IDLE;
                    else if (sof_i) st_d = ST_RUN;
      default:      st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_RUN;
    else         st_q <= st_d;
  end

  assign hunt_o = (st_q != ST_RUN);
endmodule

// File: rtl/j1850_err_vector.sv
module j1850_err_vector
  import j1850_err_pkg::*;
#(
  parameter int unsigned QDEPTH      = 2,
  parameter int unsigned SOF_CHK_CYC = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sym_sof_i,
  input  logic       sym_eod_i,
  input  logic       sym_eof_i,
  input  logic       sym_brk_i,
  input  logic       sym_bad_i,
  input  logic       sym_act_i,
  input  logic       byte_edge_i,
  input  logic [7:0] rx_data_i,
  input  logic       rx_valid_i,
  input  logic       tx_active_i,
  input  logic       tx_eod_i,
  input  logic       tx_sof_i,
  input  logic       tx_cmd_i,
  input  logic       bus_dom_i,
  input  logic       vec_rd_i,
  output logic [7:0] vec_o,
  output logic       irq_o,
  output logic       tx_abort_o,
  output logic       tx_inhibit_o,
  output logic       hunt_o
);
  localparam int unsigned CW = (SOF_CHK_CYC > 1) ? $clog2(SOF_CHK_CYC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(SOF_CHK_CYC - 1);

  logic             hunting, live;
  logic [7:0]       crc;
  logic [NCODE-1:0] push;
  logic             frame_err, crc_err, stuck_low, abort_q;
  logic [CW-1:0]    lo_cnt_q;

  j1850_hunt_fsm i_hunt (
    .clk_i, .rst_ni,
    .brk_i     (sym_brk_i),
    .bus_dom_i (bus_dom_i),
    .sof_i     (sym_sof_i),
    .hunt_o    (hunting)
  );

  assign live = !hunting;

  j1850_crc8 #(.W(8)) i_crc (
    .clk_i, .rst_ni,
    .init_i (sym_sof_i),
    .en_i   (rx_valid_i && live),
    .data_i (rx_data_i),
    .crc_o  (crc)
  );

  // SOF driven but bus never goes active
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cnt_q <= '0;
      abort_q  <= 1'b0;
    end else begin
      if (tx_sof_i && !bus_dom_i && !abort_q) begin
        if (lo_cnt_q != CNT_LAST) lo_cnt_q <= lo_cnt_q + 1'b1;
      end else begin
        lo_cnt_q <= '0;
      end
      if (tx_cmd_i)       abort_q <= 1'b0;
      else if (stuck_low) abort_q <= 1'b1;
    end
  end

  assign stuck_low = tx_sof_i && !bus_dom_i && !abort_q && (lo_cnt_q == CNT_LAST);

  assign frame_err = live && (((sym_eod_i || sym_eof_i) && !byte_edge_i)
                              || (sym_act_i && tx_eod_i)
                              || sym_bad_i);
  assign crc_err   = live && sym_eod_i && byte_edge_i && (crc != CRC_GOOD);

  always_comb begin
    push          = '0;
    push[IDX_LOA] = live && sym_bad_i && tx_active_i;
    push[IDX_INV] = frame_err || sym_brk_i || stuck_low;
    push[IDX_CRC] = crc_err;
  end

  j1850_vec_queue #(.DEPTH(QDEPTH)) i_queue (
    .clk_i, .rst_ni,
    .push_i (push),
    .pop_i  (vec_rd_i),
    .head_o (vec_o),
    .busy_o (irq_o)
  );

  assign tx_abort_o   = abort_q;
  assign tx_inhibit_o = bus_dom_i || abort_q;
  assign hunt_o       = hunting;
endmodule

// File: rtl/j1850_err_vector_chk.sv
module j1850_err_vector_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sym_brk_i,
  input logic       sym_bad_i,
  input logic       tx_active_i,
  input logic       tx_cmd_i,
  input logic       bus_dom_i,
  input logic [7:0] vec_o,
  input logic       irq_o,
  input logic       tx_abort_o,
  input logic       tx_inhibit_o,
  input logic       hunt_o
);
  assert_irq_tracks_vec_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (vec_o != 8'h00));

  assert_vec_legal_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_o inside {8'h00, 8'h14, 8'h18, 8'h1C});

  assert_loa_first_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_bad_i && tx_active_i && !hunt_o) |=> (vec_o == 8'h14));

  assert_brk_hunts_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_brk_i |=> (hunt_o && irq_o));

  assert_inhibit_when_dom_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_dom_i |-> tx_inhibit_o);

  assert_abort_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_abort_o && !tx_cmd_i) |=> tx_abort_o);

  assert_abort_inhibits_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_abort_o |-> tx_inhibit_o);
endmodule

bind j1850_err_vector j1850_err_vector_chk i_chk (
  .clk_i, .rst_ni, .sym_brk_i, .sym_bad_i, .tx_active_i, .tx_cmd_i,
  .bus_dom_i, .vec_o, .irq_o, .tx_abort_o, .tx_inhibit_o, .hunt_o
);

// File: tb/test_j1850_err_vector.sv
module test_j1850_err_vector;
  localparam int CLK_PERIOD = 10;
  localparam int CHK_CYC    = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sym_sof_i = 0, sym_eod_i = 0, sym_eof_i = 0, sym_brk_i = 0, sym_bad_i = 0, sym_act_i = 0;
  logic byte_edge_i = 1, rx_valid_i = 0, tx_active_i = 0, tx_eod_i = 0, tx_sof_i = 0;
  logic tx_cmd_i = 0, bus_dom_i = 0, vec_rd_i = 0;
  logic [7:0] rx_data_i = 0;
  logic [7:0] vec_o;
  logic irq_o, tx_abort_o, tx_inhibit_o, hunt_o;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string      req_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  j1850_err_vector #(.QDEPTH(2), .SOF_CHK_CYC(CHK_CYC)) i_j1850_err_vector (
    .clk_i(clk), .rst_ni, .sym_sof_i, .sym_eod_i, .sym_eof_i, .sym_brk_i, .sym_bad_i,
    .sym_act_i, .byte_edge_i, .rx_data_i, .rx_valid_i, .tx_active_i, .tx_eod_i,
    .tx_sof_i, .tx_cmd_i, .bus_dom_i, .vec_rd_i, .vec_o, .irq_o, .tx_abort_o,
    .tx_inhibit_o, .hunt_o
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // monitor: compares each read against the scoreboard head
  always begin
    @(negedge clk); #1;
    if (vec_rd_i) begin
      if (exp_q.size() == 0) check(1'b0, "scoreboard-empty", vec_o, 0);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string r = req_q.pop_front();
        check(vec_o == e, r, vec_o, e);
      end
    end
  end

  task automatic expect_read(input logic [7:0] code, input string req);
    exp_q.push_back(code);
    req_q.push_back(req);
    @(negedge clk); vec_rd_i = 1;
    @(negedge clk); vec_rd_i = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r = c;
    for (int b = 7; b >= 0; b--) begin
      logic fb = r[7] ^ d[b];
      r = {r[6:0], 1'b0};
      if (fb) r = r ^ 8'h1D;
    end
    return r;
  endfunction

  task automatic send_frame(input logic [7:0] b0, b1, b2, input bit corrupt);
    logic [7:0] c = 8'hFF;
    logic [7:0] bytes [3];
    bytes[0] = b0; bytes[1] = b1; bytes[2] = b2;
    @(negedge clk); sym_sof_i = 1;
    @(negedge clk); sym_sof_i = 0;
    for (int i = 0; i < 3; i++) begin
      c = ref_crc(c, bytes[i]);
      rx_data_i = bytes[i]; rx_valid_i = 1;
      @(negedge clk); rx_valid_i = 0;
    end
    rx_data_i = ~c ^ (corrupt ? 8'h04 : 8'h00); rx_valid_i = 1;
    @(negedge clk); rx_valid_i = 0;
    byte_edge_i = 1; sym_eod_i = 1;
    @(negedge clk); sym_eod_i = 0;
  endtask

  task automatic pulse_bad(input bit txing);
    tx_active_i = txing; sym_bad_i = 1;
    @(negedge clk); sym_bad_i = 0; tx_active_i = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    check(1'b0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst_ni = 1;
    idle(1);
    // R7 reset state
    check(vec_o == 8'h00, "R7 reset vec", vec_o, 0);
    check(irq_o == 1'b0, "R7 reset irq", irq_o, 0);
    check(hunt_o == 1'b0 && tx_abort_o == 1'b0, "R7 reset hunt/abort", {hunt_o, tx_abort_o}, 0);

    // R1 good frame
    send_frame(8'h68, 8'h6A, 8'hF1, 1'b0);
    check(irq_o == 1'b0, "R1 good crc no post", irq_o, 0);
    send_frame(8'h00, 8'hFF, 8'h55, 1'b0);
    check(vec_o == 8'h00, "R1 good crc pattern2", vec_o, 0);
    // R1 corrupted check byte
    send_frame(8'h68, 8'h6A, 8'hF1, 1'b1);
    check(irq_o == 1'b1, "R1 bad crc irq", irq_o, 1);
    expect_read(8'h18, "R1 crc vector");
    expect_read(8'h00, "R7 empty read");
    check(irq_o == 1'b0, "R7 irq clears", irq_o, 0);

    // R2 receive-only bad symbol
    pulse_bad(1'b0);
    expect_read(8'h1C, "R2 inv rx");
    expect_read(8'h00, "R2 no loa");

    // R3 transmit-time bad symbol
    pulse_bad(1'b1);
    expect_read(8'h14, "R3 loa head");
    expect_read(8'h1C, "R3 inv queued");
    expect_read(8'h00, "R3 drained");

    // R4 off-boundary EOF and EOD
    byte_edge_i = 0; sym_eof_i = 1;
    @(negedge clk); sym_eof_i = 0;
    expect_read(8'h1C, "R4 eof off boundary");
    sym_eod_i = 1;
    @(negedge clk); sym_eod_i = 0; byte_edge_i = 1;
    expect_read(8'h1C, "R4 eod off boundary");
    expect_read(8'h00, "R4 drained");

    // R5 active symbol while sending EOD
    tx_eod_i = 1; sym_act_i = 1;
    @(negedge clk); sym_act_i = 0; tx_eod_i = 0;
    expect_read(8'h1C, "R5 eod collision");
    sym_act_i = 1;
    @(negedge clk); sym_act_i = 0;
    expect_read(8'h00, "R5 active alone ignored");

    // R8 three codes, lowest dropped
    send_frame(8'h12, 8'h34, 8'h56, 1'b1);
    pulse_bad(1'b1);
    expect_read(8'h14, "R8 order 1");
    expect_read(8'h1C, "R8 order 2");
    expect_read(8'h00, "R8 crc dropped");

    // R6 BREAK and recovery
    bus_dom_i = 1; sym_brk_i = 1;
    @(negedge clk); sym_brk_i = 0;
    check(hunt_o == 1'b1, "R6 hunt set", hunt_o, 1);
    check(irq_o == 1'b1, "R6 irq", irq_o, 1);
    check(tx_inhibit_o == 1'b1, "R9 inhibit while dominant", tx_inhibit_o, 1);
    pulse_bad(1'b1);
    sym_eod_i = 1; byte_edge_i = 0;
    @(negedge clk); sym_eod_i = 0; byte_edge_i = 1;
    expect_read(8'h1C, "R6 brk vector");
    expect_read(8'h00, "R6 events ignored while hunting");
    bus_dom_i = 0;
    idle(2);
    check(hunt_o == 1'b1, "R6 still waiting for sof", hunt_o, 1);
    check(tx_inhibit_o == 1'b0, "R9 inhibit released", tx_inhibit_o, 0);
    sym_eof_i = 1; byte_edge_i = 0;
    @(negedge clk); sym_eof_i = 0; byte_edge_i = 1;
    expect_read(8'h00, "R6 ignored while awaiting sof");
    send_frame(8'hA1, 8'hB2, 8'hC3, 1'b0);
    check(hunt_o == 1'b0, "R6 sof ends hunt", hunt_o, 0);
    check(irq_o == 1'b0, "R6 clean frame after recovery", irq_o, 0);
    pulse_bad(1'b0);
    expect_read(8'h1C, "R6 events accepted again");

    // R10 SOF never seen on bus
    tx_sof_i = 1; bus_dom_i = 0;
    idle(CHK_CYC - 2);
    check(tx_abort_o == 1'b0, "R10 no abort before window", tx_abort_o, 0);
    idle(4);
    check(tx_abort_o == 1'b1, "R10 abort", tx_abort_o, 1);
    check(tx_inhibit_o == 1'b1, "R10 inhibit with abort", tx_inhibit_o, 1);
    tx_sof_i = 0;
    expect_read(8'h1C, "R10 vector");
    expect_read(8'h00, "R10 posted once");
    idle(3);
    check(tx_abort_o == 1'b1, "R10 abort holds", tx_abort_o, 1);
    tx_cmd_i = 1;
    @(negedge clk); tx_cmd_i = 0;
    check(tx_abort_o == 1'b0, "R10 cleared by command", tx_abort_o, 0);
    check(tx_inhibit_o == 1'b0, "R10 inhibit released", tx_inhibit_o, 0);

    idle(3);
    if (exp_q.size() != 0) check(1'b0, "scoreboard-leftover", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule